// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a 10-bit successive-approximation analog-to-digital conversion over up to four analog inputs. It selects an input on the analog multiplexer and runs a one-cycle sample phase. It then presents a trial code to the external DAC for each result bit, most significant bit first, and keeps or drops that bit according to a one-bit comparator input. Each finished code goes into a result register owned by the converted input.

Software uses a small register port with a write strobe, an address, write data and a combinational read-back. It selects one of two operating modes. In single mode, one chosen input is converted once, and the block then goes idle by itself. In continuous scan mode, a group of inputs is converted in ascending order from input 0, and the group is walked again and again until software stops it. A conversion is started by software. In scan mode it can also be started by a timer pulse or by an external trigger pin. A sticky completion flag, gated by an enable bit, forms the interrupt line. There is no streaming data path, so every pin is a plain control or status signal.

Register map (byte-free word addresses). Address 0 is control: bit 0 run/busy, bit 1 scan mode (1) or single mode (0), bits 3:2 the input number in single mode or the last input of the group in scan mode, bit 4 hardware-trigger enable. Address 1 is status: bit 0 completion flag, bit 1 interrupt enable. Addresses 4 to 7 hold the results of inputs 0 to 3, zero-extended. All other addresses read 0.

Top module: `adc_seq`

## Requirements
- R1: With an ideal comparator (cmp_in = 1 when the selected input is at least dac_code), each stored result equals the input value exactly, including 0x000 and 0x3FF. The trial codes are tried from bit 9 down to bit 0.
- R2: In single mode, writing control with bit 0 = 1 converts the input named in bits 3:2 once. Control bit 0 reads 1 from the cycle after the write for 12 cycles, then reads 0.
- R3: A finished result is written only to the result register at address 4 + n of the converted input n. The other result registers keep their values. All registers read 0 after reset.
- R4: The completion flag (status bit 0) is set when a single-mode conversion ends, or when the last input of a scan pass ends. It stays set until status is written with bit 0 = 0. Writing 1 there has no effect.
- R5: irq equals the completion flag AND the interrupt-enable bit (status bit 1) in every cycle.
- R6: Every input takes exactly 12 cycles, and mux_sel holds that input for all of them. In scan mode, the inputs follow 0, 1, ... up to the group's last input.
- R7: In scan mode, after the group's last input the sequence restarts at input 0. This goes on while control bit 0 stays 1, and the completion flag is set again at the end of every pass.
- R8: Writing control with bit 0 = 0 during a conversion stops it at the next edge. The stopped input's result register is not written, and the completion flag is not set.
- R9: While the block is idle, in scan mode and with bit 4 set, a pulse on timer_trig or ext_trig starts a scan. In single mode, or with bit 4 clear, the trigger pins have no effect.
- R10: While control bit 0 is 1, a control write changes none of bits 4:1.
- R11: sample is high only in the first cycle of each input's 12-cycle slot, and dac_code is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and read-back |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 10 | Combinational read-back of reg_addr |
| timer_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | External trigger input |
| cmp_in | input | 1 | Comparator decision: input at or above dac_code |
| mux_sel | output | 2 | Analog multiplexer select |
| dac_code | output | 10 | Trial code for the comparator reference |
| sample | output | 1 | Sample phase strobe |
| irq | output | 1 | Interrupt request |

## Verification
The inputs are set to all-ones, all-zeros and the two alternating bit patterns. An error in a single bit decision, or in the order of the decisions, therefore shows up as a wrong stored code rather than being hidden by a symmetric value. Single conversions on several inputs are contrasted with scan groups of two and four inputs. This separates a wrong channel step or wrap-around from a wrong result slot. Mid-conversion stops and control writes during a busy period show whether stale writes or lost fields leak through. Triggers are pulsed under each mode and enable combination to tell an accepted hardware start from one that should be ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // register port geometry
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RES0 = 3'd4;

  // control field positions; the group field follows B_GRP_LO
  localparam int unsigned B_START  = 0;
  localparam int unsigned B_SCAN   = 1;
  localparam int unsigned B_GRP_LO = 2;

  // status field positions
  localparam int unsigned B_DONE = 0;
  localparam int unsigned B_IEN  = 1;
endpackage

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 10,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic [CH_W-1:0]     first_ch,
  input  logic                abort,
  input  logic                active,
  input  logic                scan,
  input  logic [CH_W-1:0]     grp,
  input  logic                cmp_in,
  output logic [CH_W-1:0]     chan,
  output logic [RES_BITS-1:0] dac_code,
  output logic                sample,
  output logic                wb,
  output logic                wb_last,
  output logic [RES_BITS-1:0] wb_data
);
  localparam int STEPS  = RES_BITS + 2;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0]   step_q;
  logic [RES_BITS-1:0] sar_q;
  logic [CH_W-1:0]     chan_q;
  logic [RES_BITS-1:0] trial_mask;

  // one trial bit per decision step: step 1 tests the top bit
  for (genvar gi = 0; gi < RES_BITS; gi++) begin : g_mask
    assign trial_mask[gi] = active && (step_q == STEP_W'(RES_BITS - gi));
  end

  assign dac_code = sar_q | trial_mask;
  assign sample   = active && (step_q == '0);
  assign wb       = active && (step_q == STEP_LAST) && !abort;
  assign wb_last  = wb && (!scan || (chan_q == grp));
  assign wb_data  = sar_q;
  assign chan     = chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      sar_q  <= '0;
      chan_q <= '0;
    end else if (launch) begin
      step_q <= '0;
      sar_q  <= '0;
      chan_q <= first_ch;
    end else if (abort) begin
      step_q <= '0;
    end else if (active) begin
      if (step_q == STEP_LAST) begin
        step_q <= '0;
        sar_q  <= '0;
        if (!wb_last) chan_q <= chan_q + 1'b1;
        else if (scan) chan_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
        if (cmp_in) sar_q <= sar_q | trial_mask;
      end
    end
  end

  // R6: the selected input does not move inside its slot
  p_chan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (step_q != STEP_LAST) && !abort) |=> $stable(chan_q));

  // R7: a finished scan pass wraps back to input 0
  p_scan_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_last && scan) |=> (chan_q == '0));

  // R11: the step counter never leaves its slot range
  p_step_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_LAST);
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 10,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int WR_W    = B_GRP_LO + CH_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WR_W-1:0]     wdata,
  output logic [RES_BITS-1:0] rdata,
  input  logic                timer_trig,
  input  logic                ext_trig,
  input  logic                wb,
  input  logic                wb_last,
  input  logic [CH_W-1:0]     wb_ch,
  input  logic [RES_BITS-1:0] wb_data,
  output logic                active,
  output logic                scan,
  output logic [CH_W-1:0]     grp,
  output logic                launch,
  output logic [CH_W-1:0]     first_ch,
  output logic                abort,
  output logic                irq
);
  localparam int B_TRIG = B_GRP_LO + CH_W;

  logic                               start_q, scan_q, trig_q, done_q, ien_q;
  logic [CH_W-1:0]                    grp_q;
  logic [NUM_CH-1:0][RES_BITS-1:0]    res_q;
  logic                               ctrl_wr, stat_wr, hw_go;
  logic [ADDR_W-1:0]                  res_idx;

  assign ctrl_wr = wr && (addr == ADDR_CTRL);
  assign stat_wr = wr && (addr == ADDR_STAT);
  assign hw_go   = scan_q && trig_q && (timer_trig || ext_trig);

  assign launch   = !start_q && (ctrl_wr ? wdata[B_START] : hw_go);
  assign abort    = start_q && ctrl_wr && !wdata[B_START];
  assign first_ch = (ctrl_wr && !wdata[B_SCAN]) ? wdata[B_GRP_LO +: CH_W] : '0;

  assign active = start_q;
  assign scan   = scan_q;
  assign grp    = grp_q;
  assign irq    = done_q && ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      scan_q  <= 1'b0;
      trig_q  <= 1'b0;
      grp_q   <= '0;
    end else begin
      if (ctrl_wr && !start_q) begin
        scan_q <= wdata[B_SCAN];
        grp_q  <= wdata[B_GRP_LO +: CH_W];
        trig_q <= wdata[B_TRIG];
      end
      if (launch) start_q <= 1'b1;
      else if (abort) start_q <= 1'b0;
      else if (wb_last && !scan_q) start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (stat_wr) ien_q <= wdata[B_IEN];
      if (wb_last) done_q <= 1'b1;
      else if (stat_wr && !wdata[B_DONE]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wb && (wb_ch == CH_W'(i))) res_q[i] <= wb_data;
      end
    end
  end

  assign res_idx = addr - ADDR_RES0;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[B_START]             = start_q;
      rdata[B_SCAN]              = scan_q;
      rdata[B_GRP_LO +: CH_W]    = grp_q;
      rdata[B_TRIG]              = trig_q;
    end else if (addr == ADDR_STAT) begin
      rdata[B_DONE] = done_q;
      rdata[B_IEN]  = ien_q;
    end else if ((addr >= ADDR_RES0) && (res_idx < ADDR_W'(NUM_CH))) begin
      rdata = res_q[res_idx[CH_W-1:0]];
    end
  end

  // R2: single mode drops the busy bit after its only write-back
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !scan_q && wb_last) |=> !start_q);

  // R4: completion sets the flag
  p_done_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_last |=> done_q);

  // R4: only an explicit zero write clears the flag
  p_done_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(stat_wr && !wdata[B_DONE])) |=> done_q);

  // R8: a stop leaves the block idle with results untouched
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!start_q && $stable(res_q) && ($past(done_q) == done_q)));

  // R9: in single mode only a control write can start the block
  p_trig_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q && !scan_q && !ctrl_wr) |=> !start_q);

  // R10: configuration fields are frozen while busy
  p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> ($stable(scan_q) && $stable(grp_q) && $stable(trig_q)));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 10,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int WR_W    = B_GRP_LO + CH_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WR_W-1:0]     reg_wdata,
  output logic [RES_BITS-1:0] reg_rdata,
  input  logic                timer_trig,
  input  logic                ext_trig,
  input  logic                cmp_in,
  output logic [CH_W-1:0]     mux_sel,
  output logic [RES_BITS-1:0] dac_code,
  output logic                sample,
  output logic                irq
);
  logic                active, scan, launch, abort, wb, wb_last;
  logic [CH_W-1:0]     grp, first_ch, chan;
  logic [RES_BITS-1:0] wb_data;

  adc_seq_regs #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .timer_trig (timer_trig),
    .ext_trig   (ext_trig),
    .wb         (wb),
    .wb_last    (wb_last),
    .wb_ch      (chan),
    .wb_data    (wb_data),
    .active     (active),
    .scan       (scan),
    .grp        (grp),
    .launch     (launch),
    .first_ch   (first_ch),
    .abort      (abort),
    .irq        (irq)
  );

  adc_seq_engine #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .first_ch (first_ch),
    .abort    (abort),
    .active   (active),
    .scan     (scan),
    .grp      (grp),
    .cmp_in   (cmp_in),
    .chan     (chan),
    .dac_code (dac_code),
    .sample   (sample),
    .wb       (wb),
    .wb_last  (wb_last),
    .wb_data  (wb_data)
  );

  assign mux_sel = chan;
endmodule

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [4:0] reg_wdata = 5'd0;
  logic [9:0] reg_rdata;
  logic       timer_trig = 1'b0;
  logic       ext_trig = 1'b0;
  logic       cmp_in;
  logic [1:0] mux_sel;
  logic [9:0] dac_code;
  logic       sample;
  logic       irq;

  logic [9:0] ain [4];
  int n_chk = 0;
  int n_bad = 0;
  bit run_chk = 0;
  bit finished = 0;

  // reference state
  int m_start = 0, m_scan = 0, m_grp = 0, m_trig = 0;
  int m_done = 0, m_ien = 0, m_cnt = 0, m_ch = 0;
  int m_res [4] = '{0, 0, 0, 0};

  always #2.5 clk = ~clk;

  adc_seq u_adc_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_trig(timer_trig),
    .ext_trig(ext_trig), .cmp_in(cmp_in), .mux_sel(mux_sel),
    .dac_code(dac_code), .sample(sample), .irq(irq)
  );

  // ideal comparator
  assign cmp_in = (ain[mux_sel] >= dac_code);

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    if (a == 0) return (m_trig << 4) | (m_grp << 2) | (m_scan << 1) | m_start;
    if (a == 1) return (m_ien << 1) | m_done;
    if (a >= 4) return m_res[a - 4];
    return 0;
  endfunction

  function automatic string rd_tag(input int a);
    if (a == 0) return "R2";
    if (a == 1) return "R4";
    return "R3";
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_scan = 0; m_grp = 0; m_trig = 0;
      m_done = 0; m_ien = 0; m_cnt = 0; m_ch = 0;
      for (int i = 0; i < 4; i++) m_res[i] = 0;
    end else begin
      bit cw, sw, go, dset;
      cw = reg_wr && (reg_addr == 3'd0);
      sw = reg_wr && (reg_addr == 3'd1);
      go = 0; dset = 0;
      if (m_start != 0) begin
        if (cw && !reg_wdata[0]) begin
          m_start = 0; m_cnt = 0;
        end else if (m_cnt == 11) begin
          m_res[m_ch] = ain[m_ch];
          m_cnt = 0;
          if (m_scan == 0 || m_ch == m_grp) begin
            dset = 1;
            if (m_scan == 0) m_start = 0; else m_ch = 0;
          end else m_ch++;
        end else m_cnt++;
      end else begin
        if (cw) begin
          m_scan = reg_wdata[1]; m_grp = reg_wdata[3:2]; m_trig = reg_wdata[4];
          go = reg_wdata[0];
        end else if (m_scan != 0 && m_trig != 0 && (timer_trig || ext_trig)) go = 1;
        if (go) begin
          m_start = 1; m_cnt = 0; m_ch = (m_scan != 0) ? 0 : m_grp;
        end
      end
      if (sw) begin
        m_ien = reg_wdata[1];
        if (!reg_wdata[0]) m_done = 0;
      end
      if (dset) m_done = 1;
    end
  end

  // compare every cycle, half a period after the edge
  always @(negedge clk) begin
    if (run_chk && !finished) begin
      check("R6", "mux_sel", mux_sel, m_ch);
      check("R11", "sample", sample, (m_start != 0 && m_cnt == 0) ? 1 : 0);
      check("R5", "irq", irq, m_done & m_ien);
      check(rd_tag(reg_addr), "reg_rdata", reg_rdata, exp_rd(reg_addr));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [4:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input int exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    check(tag, $sformatf("read addr %0d", a), reg_rdata, exp);
    tick();
  endtask

  task automatic pulse(input bit use_ext);
    if (use_ext) ext_trig = 1'b1; else timer_trig = 1'b1;
    tick();
    ext_trig = 1'b0; timer_trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ain[0] = 10'h3FF; ain[1] = 10'h000; ain[2] = 10'h155; ain[3] = 10'h2AA;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run_chk = 1;

    // R3 reset state
    expect_rd(3'd0, 0, "R2");
    expect_rd(3'd1, 0, "R4");
    expect_rd(3'd6, 0, "R3");

    // R1 R2 single conversion of input 2
    wr(3'd0, 5'h09);
    expect_rd(3'd0, 5'h09, "R2");
    idle(13);
    expect_rd(3'd0, 5'h08, "R2");
    expect_rd(3'd6, 10'h155, "R1");
    expect_rd(3'd4, 0, "R3");
    expect_rd(3'd1, 1, "R4");
    check("R5", "irq while disabled", irq, 0);
    wr(3'd1, 5'h03);
    expect_rd(3'd1, 3, "R4");
    check("R5", "irq enabled", irq, 1);
    wr(3'd1, 5'h02);
    expect_rd(3'd1, 2, "R4");
    check("R5", "irq after clear", irq, 0);

    // R1 extremes on inputs 0 and 1
    wr(3'd0, 5'h01);
    idle(14);
    expect_rd(3'd4, 10'h3FF, "R1");
    wr(3'd0, 5'h05);
    idle(14);
    expect_rd(3'd5, 10'h000, "R1");
    wr(3'd1, 5'h00);

    // R8 stop mid-conversion on input 1
    ain[1] = 10'h0AB;
    wr(3'd0, 5'h05);
    idle(5);
    wr(3'd0, 5'h00);
    expect_rd(3'd0, 5'h04, "R8");
    idle(12);
    expect_rd(3'd5, 10'h000, "R8");
    expect_rd(3'd1, 0, "R8");

    // R7 scan over all four inputs
    wr(3'd0, 5'h0F);
    idle(50);
    expect_rd(3'd7, 10'h2AA, "R3");
    expect_rd(3'd5, 10'h0AB, "R1");
    expect_rd(3'd1, 1, "R7");
    expect_rd(3'd0, 5'h0F, "R7");
    // R10 field write ignored while busy
    wr(3'd0, 5'h17);
    expect_rd(3'd0, 5'h0F, "R10");
    wr(3'd1, 5'h00);
    expect_rd(3'd1, 0, "R7");
    idle(48);
    expect_rd(3'd1, 1, "R7");
    wr(3'd0, 5'h00);
    expect_rd(3'd0, 5'h0E, "R8");

    // R6 two-input scan order
    wr(3'd0, 5'h07);
    check("R6", "first slot input", mux_sel, 0);
    check("R11", "first slot sample", sample, 1);
    check("R11", "sample code", dac_code, 0);
    idle(12);
    check("R6", "second slot input", mux_sel, 1);
    idle(12);
    check("R6", "wrapped input", mux_sel, 0);
    wr(3'd0, 5'h00);
    expect_rd(3'd0, 5'h06, "R8");

    // R9 trigger pins
    wr(3'd0, 5'h16);
    pulse(0);
    expect_rd(3'd0, 5'h17, "R9");
    wr(3'd0, 5'h00);
    wr(3'd0, 5'h14);
    pulse(1);
    expect_rd(3'd0, 5'h14, "R9");
    wr(3'd0, 5'h06);
    pulse(0);
    expect_rd(3'd0, 5'h06, "R9");
    wr(3'd0, 5'h16);
    pulse(1);
    expect_rd(3'd0, 5'h17, "R9");
    wr(3'd0, 5'h00);
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule